// File: doc/BRIEF.md
# Double-data-rate two-word-burst SRAM port

This block is a synthesizable model of a common-I/O synchronous SRAM port. Every transaction moves exactly two words in one clock period of bus activity. A command is taken on each rising edge of the main clock `clk_k`. It consists of an active-low load strobe, a read/write select and a word address. Write data and per-byte write enables are taken twice per write: once on the rising edge of the inverted twin clock `clk_kn`, and once on the next rising edge of `clk_k`. Each of the two beats has its own byte mask. Read words leave on the two phases of an output reference clock pair. The data bus is enabled only while those two words are on it.

The two words of a burst form an aligned pair. The word the address names comes first, and the second word is the same address with its lowest bit inverted. A parameter restricts bursts to even starting words, as the narrowest configurations require. A second parameter states that the output clock pins are strapped high, so that the input clocks act as the output reference. The echo clock outputs copy the active output reference continuously, even while the bus is released. The storage is a small parameterised register array, split into byte lanes.

Top module: `ddrb2_sram`

## Requirements
- R1: A command is accepted only when `ld_n` is low at a rising edge of `clk_k`. With `ld_n` high the port is deselected. Address, select and data at that edge then change no stored word and do not drive the bus.
- R2: With `ld_n` low, `rw` = 1 selects a read and `rw` = 0 selects a write.
- R3: A read at start address A returns word A as the first beat and word A with bit 0 inverted as the second beat.
- R4: For a write accepted at `clk_k` edge N, the first beat is taken at the following `clk_kn` rising edge and stored at the start address. The second beat is taken at `clk_k` edge N+1 and stored at the paired address.
- R5: Each beat has its own byte mask `bw_n`. Bit g covers data bits [g*BYTE_W +: BYTE_W]. A 0 writes that lane, and a 1 leaves the stored lane unchanged.
- R6: With ODD_START = 1, a burst may start on either word. With ODD_START = 0, bit 0 of the start address is taken as 0.
- R7: For a read accepted at `clk_k` edge N, the first word is driven from the `clk_cn` rising edge at N+1.5 cycles. The second word is driven from the `clk_c` rising edge at N+2. `q_oe` is 1 over exactly those two beats and 0 otherwise.
- R8: With OCLK_STRAPPED = 1 (output clock pins held high), `clk_k` and `clk_kn` take the places of `clk_c` and `clk_cn` as the output references.
- R9: `echo` follows the second-beat reference clock and `echo_n` follows the first-beat reference clock, whether or not the bus is driven.
- R10: A read issued in the cycle right after a write to the same address returns the newly written data.
- R11: While `rst_n` is low, and after it rises until a read reaches the bus, `q_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Main input clock; commands and second write beat |
| clk_kn | input | 1 | Inverted twin of clk_k; first write beat |
| clk_c | input | 1 | Output reference for the second read word |
| clk_cn | input | 1 | Output reference for the first read word |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | 1 = read, 0 = write |
| sa | input | ADDR_W | Word address of the burst start |
| bw_n | input | BYTES | Active-low byte write enables, one per lane |
| d | input | BYTES*BYTE_W | Write data |
| q | output | BYTES*BYTE_W | Read data toward the shared pad |
| q_oe | output | 1 | Pad output enable; 0 means high impedance |
| echo | output | 1 | Free-running echo of the second-beat reference |
| echo_n | output | 1 | Free-running echo of the first-beat reference |

## Verification
A wrong command register or a wrong burst pointer shows at the ports within two and a half cycles. The beat the next read places on `q` either holds the wrong word or arrives at the wrong time, and `q_oe` does not cover exactly the two beats. A byte lane written wrongly stays hidden until that word is read again. For that reason the bench writes under every combination of the two per-beat masks and reads the word back at once. It also sweeps every start address under both start-address settings, so a mistake in the pair inversion or in the even-start forcing shows as a swapped or repeated word.

// File: rtl/ddrb2_pkg.sv
`timescale 1ns/1ps
package ddrb2_pkg;
   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } op_e;
endpackage

// File: rtl/ddrb2_cmd_stage.sv
`timescale 1ns/1ps
// Command register (main clock) and first-beat write capture (twin clock).
module ddrb2_cmd_stage
   import ddrb2_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int BYTES     = 2,
   parameter int BYTE_W    = 9,
   parameter bit ODD_START = 1'b1,
   localparam int DATA_W   = BYTES * BYTE_W
) (
   input  logic              clk_k,
   input  logic              clk_kn,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              rw,
   input  logic [ADDR_W-1:0] sa,
   input  logic [BYTES-1:0]  bw_n,
   input  logic [DATA_W-1:0] d,
   output logic              cmd_vld,
   output op_e               cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] beat0_d,
   output logic [BYTES-1:0]  beat0_m_n
);
   logic [ADDR_W-1:0] start_addr;

   generate
      if (ODD_START) begin : g_any_start
         assign start_addr = sa;
      end else begin : g_even_start
         assign start_addr = sa & ~ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld  <= 1'b0;
         cmd_op   <= OP_WRITE;
         cmd_addr <= '0;
      end else begin
         cmd_vld <= !ld_n;
         if (!ld_n) begin
            cmd_op   <= op_e'(rw);
            cmd_addr <= start_addr;
         end
      end
   end

   always_ff @(posedge clk_kn) begin
      beat0_d   <= d;
      beat0_m_n <= bw_n;
   end
endmodule

// File: rtl/ddrb2_array.sv
`timescale 1ns/1ps
// Byte-lane register array: one paired two-word write, one paired two-word read.
module ddrb2_array #(
   parameter int ADDR_W  = 4,
   parameter int BYTES   = 2,
   parameter int BYTE_W  = 9,
   localparam int DATA_W = BYTES * BYTE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata0,
   input  logic [BYTES-1:0]  wmask0_n,
   input  logic [DATA_W-1:0] wdata1,
   input  logic [BYTES-1:0]  wmask1_n,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata0,
   output logic [DATA_W-1:0] rdata1
);
   logic [ADDR_W-1:0] wpair;
   logic [ADDR_W-1:0] rpair;

   assign wpair = waddr ^ ADDR_W'(1);
   assign rpair = raddr ^ ADDR_W'(1);

   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_lane
         logic [BYTE_W-1:0] lane_mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we) begin
               if (!wmask0_n[g]) lane_mem[waddr] <= wdata0[g*BYTE_W +: BYTE_W];
               if (!wmask1_n[g]) lane_mem[wpair] <= wdata1[g*BYTE_W +: BYTE_W];
            end
         end

         assign rdata0[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
         assign rdata1[g*BYTE_W +: BYTE_W] = lane_mem[rpair];
      end
   endgenerate
endmodule

// File: rtl/ddrb2_out_stage.sv
`timescale 1ns/1ps
// Read holding register, two-phase launch and output reference selection.
module ddrb2_out_stage #(
   parameter int DATA_W        = 18,
   parameter bit OCLK_STRAPPED = 1'b0
) (
   input  logic              clk_k,
   input  logic              clk_kn,
   input  logic              clk_c,
   input  logic              clk_cn,
   input  logic              rst_n,
   input  logic              rd_take,
   input  logic [DATA_W-1:0] rdata0,
   input  logic [DATA_W-1:0] rdata1,
   output logic [DATA_W-1:0] q,
   output logic              q_oe,
   output logic              echo,
   output logic              echo_n
);
   logic              ref_p;
   logic              ref_n;
   logic              hold_vld;
   logic [DATA_W-1:0] hold0;
   logic [DATA_W-1:0] hold1;
   logic              b0_vld;
   logic [DATA_W-1:0] b0_q;
   logic [DATA_W-1:0] b1_stage;
   logic              b1_vld;
   logic [DATA_W-1:0] b1_q;

   generate
      if (OCLK_STRAPPED) begin : g_kref
         logic unused_oclk;
         assign ref_p       = clk_k;
         assign ref_n       = clk_kn;
         assign unused_oclk = clk_c & clk_cn;
      end else begin : g_cref
         logic unused_kn;
         assign ref_p     = clk_c;
         assign ref_n     = clk_cn;
         assign unused_kn = clk_kn;
      end
   endgenerate

   // Both words are taken one cycle after the read command.
   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld <= 1'b0;
      end else begin
         hold_vld <= rd_take;
      end
   end

   always_ff @(posedge clk_k) begin
      if (rd_take) begin
         hold0 <= rdata0;
         hold1 <= rdata1;
      end
   end

   // First word launches on the first-beat reference edge.
   always_ff @(posedge ref_n or negedge rst_n) begin
      if (!rst_n) begin
         b0_vld <= 1'b0;
      end else begin
         b0_vld <= hold_vld;
      end
   end

   always_ff @(posedge ref_n) begin
      b0_q     <= hold0;
      b1_stage <= hold1;
   end

   // Second word launches half a cycle later.
   always_ff @(posedge ref_p or negedge rst_n) begin
      if (!rst_n) begin
         b1_vld <= 1'b0;
      end else begin
         b1_vld <= b0_vld;
      end
   end

   always_ff @(posedge ref_p) begin
      b1_q <= b1_stage;
   end

   assign q      = ref_p ? b1_q   : b0_q;
   assign q_oe   = ref_p ? b1_vld : b0_vld;
   assign echo   = ref_p;
   assign echo_n = ref_n;
endmodule

// File: rtl/ddrb2_sram.sv
`timescale 1ns/1ps
module ddrb2_sram
   import ddrb2_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int BYTES         = 2,
   parameter int BYTE_W        = 9,
   parameter bit ODD_START     = 1'b1,
   parameter bit OCLK_STRAPPED = 1'b0,
   localparam int DATA_W       = BYTES * BYTE_W
) (
   input  logic              clk_k,
   input  logic              clk_kn,
   input  logic              clk_c,
   input  logic              clk_cn,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              rw,
   input  logic [ADDR_W-1:0] sa,
   input  logic [BYTES-1:0]  bw_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q,
   output logic              q_oe,
   output logic              echo,
   output logic              echo_n
);
   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 10) else $error("ADDR_W out of range");
      assert (BYTES >= 1) else $error("BYTES must be positive");
      assert (BYTE_W >= 1) else $error("BYTE_W must be positive");
   end

   logic              cmd_vld;
   op_e               cmd_op;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] beat0_d;
   logic [BYTES-1:0]  beat0_m_n;
   logic              cmd_rd;
   logic              cmd_wr;
   logic [DATA_W-1:0] rdata0;
   logic [DATA_W-1:0] rdata1;

   assign cmd_rd = cmd_vld && (cmd_op == OP_READ);
   assign cmd_wr = cmd_vld && (cmd_op == OP_WRITE);

   ddrb2_cmd_stage #(
      .ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W), .ODD_START(ODD_START)
   ) u_cmd (
      .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n),
      .ld_n(ld_n), .rw(rw), .sa(sa), .bw_n(bw_n), .d(d),
      .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .beat0_d(beat0_d), .beat0_m_n(beat0_m_n)
   );

   // Writes commit on the edge that carries the second beat.
   ddrb2_array #(
      .ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)
   ) u_arr (
      .clk(clk_k), .we(cmd_wr), .waddr(cmd_addr),
      .wdata0(beat0_d), .wmask0_n(beat0_m_n),
      .wdata1(d), .wmask1_n(bw_n),
      .raddr(cmd_addr), .rdata0(rdata0), .rdata1(rdata1)
   );

   ddrb2_out_stage #(
      .DATA_W(DATA_W), .OCLK_STRAPPED(OCLK_STRAPPED)
   ) u_out (
      .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn),
      .rst_n(rst_n), .rd_take(cmd_rd), .rdata0(rdata0), .rdata1(rdata1),
      .q(q), .q_oe(q_oe), .echo(echo), .echo_n(echo_n)
   );
endmodule

// File: rtl/ddrb2_sram_chk.sv
`timescale 1ns/1ps
module ddrb2_sram_chk #(
   parameter int ADDR_W    = 4,
   parameter bit ODD_START = 1'b1
) (
   input logic              clk_k,
   input logic              rst_n,
   input logic              ld_n,
   input logic              rw,
   input logic              q_oe,
   input logic              cmd_vld,
   input logic              cmd_rd,
   input logic [ADDR_W-1:0] cmd_addr
);
   logic [1:0] since_rst;

   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_cmd_capture_r1: assert property (@(posedge clk_k) disable iff (!rst_n)
      (since_rst >= 2'd1) |-> (cmd_vld == !$past(ld_n)));

   p_deselect_hold_r1: assert property (@(posedge clk_k) disable iff (!rst_n)
      (since_rst >= 2'd1 && $past(ld_n)) |-> $stable(cmd_addr));

   p_read_select_r2: assert property (@(posedge clk_k) disable iff (!rst_n)
      (since_rst >= 2'd1 && !$past(ld_n)) |-> (cmd_rd == $past(rw)));

   p_even_start_r6: assert property (@(posedge clk_k) disable iff (!rst_n)
      (!ODD_START && cmd_vld) |-> !cmd_addr[0]);

   p_read_drives_r7: assert property (@(posedge clk_k) disable iff (!rst_n)
      (since_rst >= 2'd2 && $past(!ld_n && rw, 2)) |-> q_oe);

   p_idle_released_r7: assert property (@(posedge clk_k) disable iff (!rst_n)
      (since_rst >= 2'd2 && $past(ld_n || !rw, 2)) |-> !q_oe);
endmodule

bind ddrb2_sram ddrb2_sram_chk #(.ADDR_W(ADDR_W), .ODD_START(ODD_START)) u_chk (
   .clk_k(clk_k), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .q_oe(q_oe),
   .cmd_vld(cmd_vld), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr)
);

// File: tb/sim_ddrb2_sram.sv
`timescale 1ns/1ps
module sim_ddrb2_sram;
   localparam int AW = 3;
   localparam int NB = 2;
   localparam int BW = 4;
   localparam int DW = NB * BW;
   localparam int NC = 200;

   logic clk_k = 1'b0;
   logic clk_kn;
   logic rst_n;
   logic ld_n;
   logic rw;
   logic [AW-1:0] sa;
   logic [NB-1:0] bw_n;
   logic [DW-1:0] d;
   logic [DW-1:0] q0, q1;
   logic oe0, oe1, echo0, echo1, echon0, echon1;

   always #10 clk_k = ~clk_k;
   assign clk_kn = ~clk_k;

   ddrb2_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW), .ODD_START(1'b1), .OCLK_STRAPPED(1'b0)) u0 (
      .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_k), .clk_cn(clk_kn), .rst_n(rst_n),
      .ld_n(ld_n), .rw(rw), .sa(sa), .bw_n(bw_n), .d(d),
      .q(q0), .q_oe(oe0), .echo(echo0), .echo_n(echon0));

   ddrb2_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW), .ODD_START(1'b0), .OCLK_STRAPPED(1'b1)) u1 (
      .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(1'b1), .clk_cn(1'b1), .rst_n(rst_n),
      .ld_n(ld_n), .rw(rw), .sa(sa), .bw_n(bw_n), .d(d),
      .q(q1), .q_oe(oe1), .echo(echo1), .echo_n(echon1));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // stimulus and expected values
   int ncmd = 0;
   bit            s_ld [NC];
   bit            s_rw [NC];
   logic [AW-1:0] s_a  [NC];
   logic [DW-1:0] s_x0 [NC];
   logic [NB-1:0] s_m0 [NC];
   logic [DW-1:0] s_x1 [NC];
   logic [NB-1:0] s_m1 [NC];
   string         s_tag[NC];
   bit            e_rd [NC];
   logic [DW-1:0] e0_b0[NC], e0_b1[NC], e1_b0[NC], e1_b1[NC];
   logic [DW-1:0] gm0 [8];
   logic [DW-1:0] gm1 [8];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] mrg(logic [DW-1:0] old_v, logic [DW-1:0] new_v, logic [NB-1:0] m);
      logic [DW-1:0] r;
      r = old_v;
      for (int g = 0; g < NB; g++) if (!m[g]) r[g*BW +: BW] = new_v[g*BW +: BW];
      return r;
   endfunction

   function automatic logic [DW-1:0] pat(int k);
      return DW'((k * 73 + 29) ^ (k >> 2));
   endfunction

   task automatic push(input bit ld, input bit rwi, input logic [AW-1:0] a,
                       input logic [DW-1:0] x0, input logic [NB-1:0] m0,
                       input logic [DW-1:0] x1, input logic [NB-1:0] m1, input string tag);
      logic [AW-1:0] s1;
      s1 = a & 3'b110;
      s_ld[ncmd] = ld; s_rw[ncmd] = rwi; s_a[ncmd] = a;
      s_x0[ncmd] = x0; s_m0[ncmd] = m0; s_x1[ncmd] = x1; s_m1[ncmd] = m1;
      s_tag[ncmd] = tag;
      e_rd[ncmd] = !ld && rwi;
      if (!ld && rwi) begin
         e0_b0[ncmd] = gm0[a];  e0_b1[ncmd] = gm0[a ^ 3'd1];
         e1_b0[ncmd] = gm1[s1]; e1_b1[ncmd] = gm1[s1 ^ 3'd1];
      end
      if (!ld && !rwi) begin
         gm0[a]         = mrg(gm0[a], x0, m0);
         gm0[a ^ 3'd1]  = mrg(gm0[a ^ 3'd1], x1, m1);
         gm1[s1]        = mrg(gm1[s1], x0, m0);
         gm1[s1 ^ 3'd1] = mrg(gm1[s1 ^ 3'd1], x1, m1);
      end
      ncmd++;
   endtask

   task automatic wr(input int a, input int k, input logic [NB-1:0] m0, input logic [NB-1:0] m1, input string tag);
      push(1'b0, 1'b0, AW'(a), pat(k), m0, pat(k + 101), m1, tag);
   endtask

   task automatic rd(input int a, input string tag);
      push(1'b0, 1'b1, AW'(a), pat(a + 7), 2'b00, pat(a + 9), 2'b00, tag);
   endtask

   task automatic idle(input int k);
      push(1'b1, k[0], AW'(k * 5), pat(k + 55), 2'b00, pat(k + 77), 2'b00, "R1");
   endtask

   // check one beat of command j on both instances
   task automatic beat_chk(input int j, input bit second);
      bit rdv;
      logic [DW-1:0] x0, x1;
      string tg;
      rdv = (j >= 0 && j < ncmd) ? e_rd[j] : 1'b0;
      tg  = (j >= 0 && j < ncmd) ? s_tag[j] : "R7";
      chk(oe0 == rdv, "R7", second ? "u0 oe beat1" : "u0 oe beat0", 32'(oe0), 32'(rdv));
      chk(oe1 == rdv, "R7 R8", second ? "u1 oe beat1" : "u1 oe beat0", 32'(oe1), 32'(rdv));
      if (rdv) begin
         x0 = second ? e0_b1[j] : e0_b0[j];
         x1 = second ? e1_b1[j] : e1_b0[j];
         chk(q0 === x0, tg, second ? "u0 beat1 data" : "u0 beat0 data", 32'(q0), 32'(x0));
         chk(q1 === x1, {tg, " R6 R8"}, second ? "u1 beat1 data" : "u1 beat0 data", 32'(q1), 32'(x1));
      end
   endtask

   task automatic build;
      // fill every word with full-lane writes (R4: beat0 at twin edge, beat1 next edge)
      for (int a = 0; a < 8; a += 2) wr(a, a, 2'b00, 2'b00, "R4");
      idle(1);
      wr(1, 40, 2'b00, 2'b00, "R4");
      wr(5, 41, 2'b00, 2'b00, "R4");
      // every start address, back to back
      for (int a = 0; a < 8; a++) rd(a, "R3");
      idle(2);
      // all per-beat mask combinations, each read back at once
      for (int k = 0; k < 16; k++) begin
         wr(k % 8, 200 + k, NB'(k & 3), NB'((k >> 2) & 3), "R5");
         rd(k % 8, "R5");
         if (k % 4 == 3) idle(k);
      end
      // write immediately followed by read of the same address
      for (int a = 0; a < 8; a++) begin
         wr(a, 300 + a, 2'b00, 2'b00, "R10");
         rd(a, "R10");
         rd(a ^ 1, "R10");
      end
      // deselected cycles carrying addresses, data and enabled lanes
      for (int k = 0; k < 6; k++) idle(k + 20);
      for (int a = 0; a < 8; a++) rd(a, "R1");
      // alternating reads and writes
      for (int k = 0; k < 8; k++) begin
         wr((k * 3) % 8, 400 + k, NB'(k & 1), NB'((k >> 1) & 1), "R2");
         rd((k * 5) % 8, "R2");
      end
      rd(7, "R6");
      rd(6, "R6");
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin gm0[i] = '0; gm1[i] = '0; end
      build();
      rst_n = 1'b0; ld_n = 1'b1; rw = 1'b0; sa = '0; bw_n = '1; d = '0;
      repeat (3) @(posedge clk_k);
      #5;
      chk(!oe0 && !oe1, "R11", "oe during reset", 32'({oe0, oe1}), 32'd0);
      rst_n = 1'b1;
      #10;
      ld_n = s_ld[0]; rw = s_rw[0]; sa = s_a[0]; bw_n = '1; d = '0;
      @(posedge clk_k);
      for (int n = 0; n < ncmd + 3; n++) begin
         #5;
         if (n < ncmd) begin d = s_x0[n]; bw_n = s_m0[n]; end
         beat_chk(n - 2, 1'b1);
         if (n < 4) chk(!oe0 && !oe1, "R11", "oe after reset", 32'({oe0, oe1}), 32'd0);
         chk(echo0 && !echon0 && echo1 && !echon1, "R9", "echo high phase",
             32'({echo0, echon0, echo1, echon1}), 32'b1010);
         #10;
         beat_chk(n - 1, 1'b0);
         chk(!echo0 && echon0 && !echo1 && echon1, "R9", "echo low phase",
             32'({echo0, echon0, echo1, echon1}), 32'b0101);
         if (n + 1 < ncmd) begin
            ld_n = s_ld[n + 1]; rw = s_rw[n + 1]; sa = s_a[n + 1];
         end else begin
            ld_n = 1'b1; rw = 1'b0; sa = '0;
         end
         if (n < ncmd) begin d = s_x1[n]; bw_n = s_m1[n]; end
         else begin d = '0; bw_n = '1; end
         @(posedge clk_k);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule